// File: doc/BRIEF.md
# Cartridge-Bus LCD Passthrough Mode Mux

This block decides who owns the cartridge connector pins and where the LCD panel gets its pixel data. In normal operation the CPU drives the cartridge address, data and strobe pins, and the LCD is fed from the internal video generator. A two-bit mode field, bits 3:2 of the CPU-mode register, can arm a passthrough variant. A header compatibility byte of 0x88 puts the code `2'b10` into that field. Once the field holds that code and the CPU executes a stop instruction, the block hands the connector over to the cartridge. All console-side pin drivers go to high impedance. The cartridge pins become inputs that feed the panel's 18-bit colour bus and its control lines. The CPU is held halted until the next reset.

In passthrough, the address pins carry the red and green components and the low three bits of blue. The low data pins carry the rest of blue, and the upper data pins carry the five panel control lines. The write strobe pin carries the start-of-line pulse, the reset pin drives the panel reset, and the read strobe pin is the pixel clock. Every passthrough signal except the pixel clock passes through a two-flop synchronizer before it reaches the panel. The pixel clock is forwarded with no flop in its path. A15 and the chip-select pin are not mapped to anything. This lets a cartridge hold them high to keep its own memories deselected.

Top module: `cbpt_lcd_passthru`

## Requirements
- R1: While reset is asserted, and after it is released, `cpu_halt` is 0. All 16 address output enables and all three strobe output enables are 1, and every LCD output equals the internal video source.
- R2: Outside passthrough, the cartridge address, data, write, read and chip-select outputs equal the CPU-side values. Every bit of `cart_data_oe` equals `cpu_dout_en`.
- R3: Passthrough is entered on the rising clock edge at which `stop_exec` is 1 and `mode_sel` (register bits 3:2) equals `2'b10`. `cpu_halt` reads 1 from that edge on and 0 before it.
- R4: A stop strobe with `mode_sel` equal to `2'b00`, `2'b01` or `2'b11` leaves `cpu_halt` at 0 and the pins in normal mode.
- R5: Once set, `cpu_halt` stays 1 whatever `mode_sel` or `stop_exec` do. Only `rst_n` low clears it, and it clears at once.
- R6: In passthrough, every bit of `cart_addr_oe`, `cart_data_oe` and `cart_strb_oe` is 0. This includes A15 and chip-select.
- R7: In passthrough, `lcd_rgb[5:0]` (red) equals pins A5..A0 and `lcd_rgb[11:6]` (green) equals pins A11..A6, two clock edges after the pins.
- R8: In passthrough, `lcd_rgb[17:12]` (blue) equals {D2, D1, D0, A14, A13, A12}, two clock edges after the pins.
- R9: In passthrough, `lcd_ctrl[4:0]` equals D7..D3, two clock edges after the pins. Bit 0 is reverse, bit 1 is CLS, bit 2 is SPS, bit 3 is PS and bit 4 is LP.
- R10: In passthrough, `lcd_spl` follows the write strobe pin and `lcd_rst_n` follows the reset pin, with exactly two clock edges of delay. After one edge the old value is still shown.
- R11: In passthrough, `lcd_dck` equals `cart_rd_in` combinationally, with no clock edge in between.
- R12: In passthrough, changes on `cart_addr_in[15]` and `cart_cs_in` alone change no LCD output.
- R13: Outside passthrough, `lcd_rgb`, `lcd_ctrl`, `lcd_spl`, `lcd_dck` and `lcd_rst_n` equal the matching video source inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Bits 3:2 of the CPU-mode register |
| stop_exec | input | 1 | One-cycle strobe: a stop instruction executed |
| cpu_addr | input | 16 | CPU-side address to drive on the pins |
| cpu_dout | input | 8 | CPU-side write data |
| cpu_dout_en | input | 1 | CPU drives the data pins |
| cpu_wr_n | input | 1 | CPU-side write strobe |
| cpu_rd_n | input | 1 | CPU-side read strobe |
| cpu_cs_n | input | 1 | CPU-side chip select |
| cart_addr_in | input | 16 | Sensed address pin levels |
| cart_data_in | input | 8 | Sensed data pin levels |
| cart_wr_in | input | 1 | Sensed write strobe pin |
| cart_rd_in | input | 1 | Sensed read strobe pin |
| cart_cs_in | input | 1 | Sensed chip-select pin |
| cart_rst_in | input | 1 | Sensed cartridge reset pin |
| vid_rgb | input | 18 | Internal video colour {blue, green, red} |
| vid_ctrl | input | 5 | Internal video panel control lines |
| vid_spl | input | 1 | Internal video start-of-line pulse |
| vid_dck | input | 1 | Internal video pixel clock |
| vid_rst_n | input | 1 | Internal video panel reset |
| cart_addr_out | output | 16 | Address pin drive value |
| cart_addr_oe | output | 16 | Address pin output enables |
| cart_data_out | output | 8 | Data pin drive value |
| cart_data_oe | output | 8 | Data pin output enables |
| cart_wr_out | output | 1 | Write strobe drive value |
| cart_rd_out | output | 1 | Read strobe drive value |
| cart_cs_out | output | 1 | Chip-select drive value |
| cart_strb_oe | output | 3 | Enables {cs, rd, wr} |
| lcd_rgb | output | 18 | Panel colour {blue, green, red} |
| lcd_ctrl | output | 5 | Panel control lines |
| lcd_spl | output | 1 | Panel start-of-line pulse |
| lcd_dck | output | 1 | Panel pixel clock |
| lcd_rst_n | output | 1 | Panel reset |
| cpu_halt | output | 1 | CPU held halted (passthrough active) |

## Verification
Random CPU bus, pin and video values are applied in normal mode. This tells apart a mux that keeps the video and CPU paths from one that leaks pin data or drops enables. In passthrough, random address and data words are pushed through the pins, and each colour field and control line is compared on its own. A swapped or shifted bit in the red, green, blue or control map then shows up. The directed cases cover the following:
- each mode code paired with a stop strobe, which separates the arming code from the other three;
- a one-edge sample, which separates the two-flop latency from a one-flop path;
- a toggle of A15 and chip-select alone, which shows those pins are unmapped;
- a pixel clock toggle sampled before any edge, which shows the clock path has no flop.

// File: rtl/cbpt_pkg.sv
package cbpt_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int COLOR_W = 6;
  localparam int CTRL_W  = 5;
  localparam int STRB_W  = 3;
  localparam int RGB_W   = 3 * COLOR_W;
  localparam logic [1:0] PT1_CODE = 2'b10;

  typedef struct packed {
    logic [RGB_W-1:0]  rgb;
    logic [CTRL_W-1:0] ctrl;
    logic              spl;
    logic              rst_n;
  } lcd_bus_t;

  localparam int LCD_BUS_W = $bits(lcd_bus_t);
endpackage

// File: rtl/cbpt_rst_sync.sv
module cbpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= 2'b00;
    else        shreg_q <= {shreg_q[0], 1'b1};
  end

  assign rst_sync_n = shreg_q[1];
endmodule

// File: rtl/cbpt_mode_ctrl.sv
module cbpt_mode_ctrl #(
  parameter logic [1:0] ARM_CODE = cbpt_pkg::PT1_CODE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       stop_exec,
  output logic       pt_active
);
  logic active_q;
  logic enter_en;

  always_comb begin
    enter_en = stop_exec && (mode_sel == ARM_CODE) && !active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active_q <= 1'b0;
    else if (enter_en) active_q <= 1'b1;
  end

  assign pt_active = active_q;
endmodule

// File: rtl/cbpt_sync.sv
module cbpt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cbpt_pin_mux.sv
module cbpt_pin_mux
  import cbpt_pkg::*;
(
  input  logic              pt_active,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_dout,
  input  logic              cpu_dout_en,
  input  logic              cpu_wr_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_cs_n,
  input  lcd_bus_t          vid_bus,
  input  logic              vid_dck,
  input  lcd_bus_t          pin_bus,
  input  logic              pin_dck,
  output logic [ADDR_W-1:0] cart_addr_out,
  output logic [ADDR_W-1:0] cart_addr_oe,
  output logic [DATA_W-1:0] cart_data_out,
  output logic [DATA_W-1:0] cart_data_oe,
  output logic              cart_wr_out,
  output logic              cart_rd_out,
  output logic              cart_cs_out,
  output logic [STRB_W-1:0] cart_strb_oe,
  output lcd_bus_t          lcd_bus,
  output logic              lcd_dck
);
  always_comb begin
    cart_addr_out = cpu_addr;
    cart_data_out = cpu_dout;
    cart_wr_out   = cpu_wr_n;
    cart_rd_out   = cpu_rd_n;
    cart_cs_out   = cpu_cs_n;
    if (pt_active) begin
      cart_addr_oe = '0;
      cart_data_oe = '0;
      cart_strb_oe = '0;
      lcd_bus      = pin_bus;
      lcd_dck      = pin_dck;
    end else begin
      cart_addr_oe = '1;
      cart_data_oe = {DATA_W{cpu_dout_en}};
      cart_strb_oe = '1;
      lcd_bus      = vid_bus;
      lcd_dck      = vid_dck;
    end
  end
endmodule

// File: rtl/cbpt_lcd_passthru.sv
module cbpt_lcd_passthru
  import cbpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_sel,
  input  logic                stop_exec,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_dout,
  input  logic                cpu_dout_en,
  input  logic                cpu_wr_n,
  input  logic                cpu_rd_n,
  input  logic                cpu_cs_n,
  input  logic [ADDR_W-1:0]   cart_addr_in,
  input  logic [DATA_W-1:0]   cart_data_in,
  input  logic                cart_wr_in,
  input  logic                cart_rd_in,
  input  logic                cart_cs_in,
  input  logic                cart_rst_in,
  input  logic [RGB_W-1:0]    vid_rgb,
  input  logic [CTRL_W-1:0]   vid_ctrl,
  input  logic                vid_spl,
  input  logic                vid_dck,
  input  logic                vid_rst_n,
  output logic [ADDR_W-1:0]   cart_addr_out,
  output logic [ADDR_W-1:0]   cart_addr_oe,
  output logic [DATA_W-1:0]   cart_data_out,
  output logic [DATA_W-1:0]   cart_data_oe,
  output logic                cart_wr_out,
  output logic                cart_rd_out,
  output logic                cart_cs_out,
  output logic [STRB_W-1:0]   cart_strb_oe,
  output logic [RGB_W-1:0]    lcd_rgb,
  output logic [CTRL_W-1:0]   lcd_ctrl,
  output logic                lcd_spl,
  output logic                lcd_dck,
  output logic                lcd_rst_n,
  output logic                cpu_halt
);
  logic     rst_int_n;
  logic     pt_active;
  lcd_bus_t pin_raw;
  lcd_bus_t pin_sync;
  lcd_bus_t vid_bus;
  lcd_bus_t lcd_bus;
  logic     unused_pins;

  // Pin-to-panel map: blue high half from low data pins, blue low half from
  // A14..A12, green from A11..A6, red from A5..A0, controls from D7..D3.
  always_comb begin
    pin_raw.rgb   = {cart_data_in[2:0], cart_addr_in[14:0]};
    pin_raw.ctrl  = cart_data_in[7:3];
    pin_raw.spl   = cart_wr_in;
    pin_raw.rst_n = cart_rst_in;
    vid_bus.rgb   = vid_rgb;
    vid_bus.ctrl  = vid_ctrl;
    vid_bus.spl   = vid_spl;
    vid_bus.rst_n = vid_rst_n;
  end

  // A15 and chip select are left off the panel on purpose.
  assign unused_pins = ^{cart_addr_in[ADDR_W-1], cart_cs_in};

  cbpt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cbpt_mode_ctrl #(.ARM_CODE(PT1_CODE)) u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_sel  (mode_sel),
    .stop_exec (stop_exec),
    .pt_active (pt_active)
  );

  cbpt_sync #(.WIDTH(LCD_BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pin_raw),
    .dout  (pin_sync)
  );

  cbpt_pin_mux u_mux (
    .pt_active     (pt_active),
    .cpu_addr      (cpu_addr),
    .cpu_dout      (cpu_dout),
    .cpu_dout_en   (cpu_dout_en),
    .cpu_wr_n      (cpu_wr_n),
    .cpu_rd_n      (cpu_rd_n),
    .cpu_cs_n      (cpu_cs_n),
    .vid_bus       (vid_bus),
    .vid_dck       (vid_dck),
    .pin_bus       (pin_sync),
    .pin_dck       (cart_rd_in),
    .cart_addr_out (cart_addr_out),
    .cart_addr_oe  (cart_addr_oe),
    .cart_data_out (cart_data_out),
    .cart_data_oe  (cart_data_oe),
    .cart_wr_out   (cart_wr_out),
    .cart_rd_out   (cart_rd_out),
    .cart_cs_out   (cart_cs_out),
    .cart_strb_oe  (cart_strb_oe),
    .lcd_bus       (lcd_bus),
    .lcd_dck       (lcd_dck)
  );

  assign lcd_rgb   = lcd_bus.rgb;
  assign lcd_ctrl  = lcd_bus.ctrl;
  assign lcd_spl   = lcd_bus.spl;
  assign lcd_rst_n = lcd_bus.rst_n;
  assign cpu_halt  = pt_active;
endmodule

// File: rtl/cbpt_lcd_passthru_chk.sv
module cbpt_lcd_passthru_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_sel,
  input logic        stop_exec,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_dout,
  input logic        cpu_dout_en,
  input logic        cpu_wr_n,
  input logic        cpu_rd_n,
  input logic        cpu_cs_n,
  input logic [15:0] cart_addr_in,
  input logic [7:0]  cart_data_in,
  input logic        cart_wr_in,
  input logic        cart_rd_in,
  input logic        cart_cs_in,
  input logic        cart_rst_in,
  input logic [17:0] vid_rgb,
  input logic [4:0]  vid_ctrl,
  input logic        vid_spl,
  input logic        vid_dck,
  input logic        vid_rst_n,
  input logic [15:0] cart_addr_out,
  input logic [15:0] cart_addr_oe,
  input logic [7:0]  cart_data_out,
  input logic [7:0]  cart_data_oe,
  input logic        cart_wr_out,
  input logic        cart_rd_out,
  input logic        cart_cs_out,
  input logic [2:0]  cart_strb_oe,
  input logic [17:0] lcd_rgb,
  input logic [4:0]  lcd_ctrl,
  input logic        lcd_spl,
  input logic        lcd_dck,
  input logic        lcd_rst_n,
  input logic        cpu_halt
);
  logic unused_chk;
  assign unused_chk = ^{cart_cs_in, cart_addr_in[15]};

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !cpu_halt);  // R1

  AST_NORMAL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt |-> (cart_addr_out == cpu_addr && cart_data_out == cpu_dout &&
                   cart_wr_out == cpu_wr_n && cart_rd_out == cpu_rd_n &&
                   cart_cs_out == cpu_cs_n && cart_data_oe == {8{cpu_dout_en}}));  // R2

  AST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_exec && mode_sel == 2'b10 && $past(rst_n)) |=> cpu_halt);  // R3

  AST_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && !(stop_exec && mode_sel == 2'b10)) |=> !cpu_halt);  // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> cpu_halt);  // R5

  AST_PINS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (cart_addr_oe == 16'h0 && cart_data_oe == 8'h0 && cart_strb_oe == 3'b000));  // R6

  AST_RG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && $past(cpu_halt, 2)) |-> lcd_rgb[11:0] == $past(cart_addr_in[11:0], 2));  // R7

  AST_B_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && $past(cpu_halt, 2)) |->
      lcd_rgb[17:12] == {$past(cart_data_in[2:0], 2), $past(cart_addr_in[14:12], 2)});  // R8

  AST_CTRL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && $past(cpu_halt, 2)) |-> lcd_ctrl == $past(cart_data_in[7:3], 2));  // R9

  AST_SPL_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && $past(cpu_halt, 2)) |->
      (lcd_spl == $past(cart_wr_in, 2) && lcd_rst_n == $past(cart_rst_in, 2)));  // R10

  AST_DCK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> lcd_dck == cart_rd_in);  // R11

  AST_VIDEO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt |-> (lcd_rgb == vid_rgb && lcd_ctrl == vid_ctrl && lcd_spl == vid_spl &&
                   lcd_dck == vid_dck && lcd_rst_n == vid_rst_n));  // R13
endmodule

bind cbpt_lcd_passthru cbpt_lcd_passthru_chk chk_i (.*);

// File: tb/cbpt_lcd_passthru_tb_top.sv
module cbpt_lcd_passthru_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        stop_exec;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_dout;
  logic        cpu_dout_en, cpu_wr_n, cpu_rd_n, cpu_cs_n;
  logic [15:0] cart_addr_in;
  logic [7:0]  cart_data_in;
  logic        cart_wr_in, cart_rd_in, cart_cs_in, cart_rst_in;
  logic [17:0] vid_rgb;
  logic [4:0]  vid_ctrl;
  logic        vid_spl, vid_dck, vid_rst_n;
  logic [15:0] cart_addr_out, cart_addr_oe;
  logic [7:0]  cart_data_out, cart_data_oe;
  logic        cart_wr_out, cart_rd_out, cart_cs_out;
  logic [2:0]  cart_strb_oe;
  logic [17:0] lcd_rgb;
  logic [4:0]  lcd_ctrl;
  logic        lcd_spl, lcd_dck, lcd_rst_n, cpu_halt;

  int n_chk;
  int n_fail;
  bit done;

  cbpt_lcd_passthru dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_rgb(input logic [15:0] a, input logic [7:0] d);
    logic [5:0] r, g, b;
    r = a[5:0];
    g = a[11:6];
    b = {d[2:0], a[14:12]};
    return {b, g, r};
  endfunction

  function automatic logic [4:0] exp_ctrl(input logic [7:0] d);
    return {d[7], d[6], d[5], d[4], d[3]};
  endfunction

  task automatic rand_inputs();
    cpu_addr     = 16'($urandom);
    cpu_dout     = 8'($urandom);
    cpu_dout_en  = 1'($urandom);
    cpu_wr_n     = 1'($urandom);
    cpu_rd_n     = 1'($urandom);
    cpu_cs_n     = 1'($urandom);
    cart_addr_in = 16'($urandom);
    cart_data_in = 8'($urandom);
    cart_wr_in   = 1'($urandom);
    cart_rd_in   = 1'($urandom);
    cart_cs_in   = 1'($urandom);
    cart_rst_in  = 1'($urandom);
    vid_rgb      = 18'($urandom);
    vid_ctrl     = 5'($urandom);
    vid_spl      = 1'($urandom);
    vid_dck      = 1'($urandom);
    vid_rst_n    = 1'($urandom);
  endtask

  task automatic check_video(input string req);
    chk({req, " rgb"}, 32'(lcd_rgb), 32'(vid_rgb));
    chk({req, " ctrl"}, 32'(lcd_ctrl), 32'(vid_ctrl));
    chk({req, " spl/dck/rst"}, {29'd0, lcd_spl, lcd_dck, lcd_rst_n},
        {29'd0, vid_spl, vid_dck, vid_rst_n});
  endtask

  task automatic check_pt();
    logic [17:0] e;
    e = exp_rgb(cart_addr_in, cart_data_in);
    chk("R7 red",   32'(lcd_rgb[5:0]),   32'(e[5:0]));
    chk("R7 green", 32'(lcd_rgb[11:6]),  32'(e[11:6]));
    chk("R8 blue",  32'(lcd_rgb[17:12]), 32'(e[17:12]));
    chk("R9 ctrl",  32'(lcd_ctrl), 32'(exp_ctrl(cart_data_in)));
    chk("R10 spl",  32'(lcd_spl), 32'(cart_wr_in));
    chk("R10 rst",  32'(lcd_rst_n), 32'(cart_rst_in));
    chk("R6 oe",    {13'd0, cart_addr_oe, cart_strb_oe}, 32'd0);
    chk("R6 data oe", 32'(cart_data_oe), 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed_dummy;
    logic [17:0] old_rgb;
    logic [4:0]  old_ctrl;
    logic        old_spl;
    seed_dummy = $urandom(32'h00C0FFEE);
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; mode_sel = 2'b00; stop_exec = 1'b0;
    rand_inputs();
    repeat (3) @(posedge clk);
    #5;
    chk("R1 halt in reset", 32'(cpu_halt), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    // R1: reset state
    chk("R1 halt", 32'(cpu_halt), 32'd0);
    chk("R1 addr oe", 32'(cart_addr_oe), 32'hFFFF);
    chk("R1 strb oe", 32'(cart_strb_oe), 32'h7);
    check_video("R1 video");

    // R2, R13: normal mode, random bus and video
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rand_inputs();
      mode_sel = 2'($urandom);
      #5;
      chk("R2 addr", 32'(cart_addr_out), 32'(cpu_addr));
      chk("R2 data", 32'(cart_data_out), 32'(cpu_dout));
      chk("R2 data oe", 32'(cart_data_oe), cpu_dout_en ? 32'hFF : 32'h0);
      chk("R2 strobes", {29'd0, cart_wr_out, cart_rd_out, cart_cs_out},
          {29'd0, cpu_wr_n, cpu_rd_n, cpu_cs_n});
      check_video("R13 video");
    end

    // R4: non-arming codes ignore stop
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      @(negedge clk);
      mode_sel = 2'(c); stop_exec = 1'b1;
      @(negedge clk);
      stop_exec = 1'b0;
      @(posedge clk); #5;
      chk("R4 no halt", 32'(cpu_halt), 32'd0);
      chk("R4 pins still driven", 32'(cart_addr_oe), 32'hFFFF);
    end

    // R3: arming code plus stop
    @(negedge clk);
    mode_sel = 2'b10; stop_exec = 1'b1;
    #2;
    chk("R3 halt before edge", 32'(cpu_halt), 32'd0);
    @(posedge clk); #5;
    chk("R3 halt after edge", 32'(cpu_halt), 32'd1);
    @(negedge clk);
    stop_exec = 1'b0;

    // R5: sticky despite mode changes and further stops
    mode_sel = 2'b00;
    @(negedge clk); stop_exec = 1'b1;
    @(negedge clk); stop_exec = 1'b0; mode_sel = 2'b11;
    repeat (10) @(posedge clk);
    #5;
    chk("R5 sticky", 32'(cpu_halt), 32'd1);

    // R7..R10, R6: random passthrough vectors
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      rand_inputs();
      @(posedge clk); @(posedge clk); #5;
      check_pt();
    end

    // R10: latency of exactly two edges
    @(negedge clk);
    cart_wr_in = 1'b0; cart_data_in = 8'h00; cart_addr_in = 16'h0000;
    @(posedge clk); @(posedge clk); #5;
    @(negedge clk);
    cart_wr_in = 1'b1; cart_data_in = 8'hFF; cart_addr_in = 16'h7FFF;
    @(posedge clk); #5;
    chk("R10 one edge old spl", 32'(lcd_spl), 32'd0);
    chk("R10 one edge old rgb", 32'(lcd_rgb), 32'd0);
    @(posedge clk); #5;
    chk("R10 two edges spl", 32'(lcd_spl), 32'd1);
    chk("R8 all-ones blue", 32'(lcd_rgb), 32'h3FFFF);

    // R11: pixel clock is combinational
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cart_rd_in = ~cart_rd_in;
      #1;
      chk("R11 dck", 32'(lcd_dck), 32'(cart_rd_in));
    end

    // R12: A15 and chip select are unmapped
    old_rgb = lcd_rgb; old_ctrl = lcd_ctrl; old_spl = lcd_spl;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cart_addr_in[15] = ~cart_addr_in[15];
      cart_cs_in = ~cart_cs_in;
      @(posedge clk); @(posedge clk); @(posedge clk); #5;
      chk("R12 rgb", 32'(lcd_rgb), 32'(old_rgb));
      chk("R12 ctrl", 32'(lcd_ctrl), 32'(old_ctrl));
      chk("R12 spl", 32'(lcd_spl), 32'(old_spl));
    end

    // R5: only reset clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R5 reset clears", 32'(cpu_halt), 32'd0);
    chk("R1 oe after reset", 32'(cart_addr_oe), 32'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #5;
    check_video("R1 video after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule